// File: doc/BRIEF.md
# Power Domain Up-Sequencer

This block brings one switchable logic domain, such as a coprocessor, out of its powered-down state by stepping through a fixed order of control changes. A single start pulse begins the run. The block then:

1. holds the domain in hardware reset;
2. raises a power-on request and waits for the power switch to acknowledge it;
3. raises a power-good request and waits for its acknowledge;
4. releases the isolation clamp;
5. finally lets the hardware-reset control return high.

Each acknowledge wait is a bounded poll. The acknowledge is sampled on a fixed interval, and the wait gives up after a set number of polls. Each accepted acknowledge is followed by a fixed settle gap, and a further settle gap separates clamp release from the last reset change.

All intervals are derived from a clock-frequency parameter. They are rounded up to whole cycles. The outcome is reported on two flags, done and a sticky timeout error, and an error-stage bit names the stage that failed. A small read-only register view reflects the control, power-enable and status bits at fixed byte offsets, so that a host can observe the state without extra wiring.

Top module: `pwr_up_seq`

## Requirements

The defaults give POLL_CYC = 100, SETTLE_CYC = 50 and POLL_LIMIT = 10. POLL_CYC is ceil(CLK_HZ × 1 µs) and SETTLE_CYC is ceil(CLK_HZ × 500 ns).

- R1: After reset:
  - hw_rst_o=1 and clamp_o=1;
  - pon_req_o=0 and pg_req_o=0;
  - busy_o=0, done_o=0, err_o=0 and err_stage_o=0.
- R2: A start pulse while idle drives hw_rst_o low and busy_o high at the first clock edge that samples it. pon_req_o rises exactly one cycle later.
- R3: Both acknowledge inputs pass a two-flop synchronizer and are polled once every POLL_CYC cycles, POLL_LIMIT times per stage. An acknowledge that rises no later than (POLL_LIMIT-1)*POLL_CYC-3 cycles after its request is accepted, and the sequence goes on without error.
- R4: If no acknowledge is accepted by the last poll, err_o rises between (POLL_LIMIT-1)*POLL_CYC and POLL_LIMIT*POLL_CYC cycles after the request rose. busy_o falls in the same cycle, and the request outputs keep their values.
- R5: err_stage_o is 0 when the power-on wait timed out and 1 when the power-good wait timed out.
- R6: pg_req_o rises between SETTLE_CYC and SETTLE_CYC+POLL_CYC+3 cycles after the power-on acknowledge rises. pon_req_o stays high from then on.
- R7: clamp_o falls between SETTLE_CYC and SETTLE_CYC+POLL_CYC+3 cycles after the power-good acknowledge rises.
- R8: hw_rst_o returns high exactly SETTLE_CYC cycles after clamp_o falls. done_o rises and busy_o falls in that same cycle.
- R9: From reset, the outputs change in exactly this order of steps, with no other changes:
  - reset low together with busy high;
  - power-on request high;
  - power-good request high;
  - clamp low;
  - reset high together with done high and busy low.
- R10: done_o stays high until the next start. A start while done re-runs the sequence: hw_rst_o falls, done_o clears, then hw_rst_o and done_o rise again.
- R11: A start pulse while busy_o is high has no effect: no extra output change, and the final timing is unchanged.
- R12: err_o stays set until reset. Start pulses while it is set change no output.
- R13: The register view is read through reg_addr_i with reg_rdata_o valid one cycle later. Reads of any other offset return 0.

  | Byte offset | Bit | Meaning |
  |---|---|---|
  | 0x0 | 6 | hw_rst_o |
  | 0x4 | 20 | clamp_o |
  | 0x4 | 21 | pon_req_o |
  | 0x4 | 22 | pg_req_o |
  | 0x8 | 0 | done |
  | 0x8 | 1 | busy |
  | 0x8 | 2 | err |
  | 0x8 | 3 | err_stage |
  | 0x8 | 21 | synchronized power-on acknowledge |
  | 0x8 | 22 | synchronized power-good acknowledge |

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| pon_ack_i | input | 1 | Power-on acknowledge from the switch (asynchronous) |
| pg_ack_i | input | 1 | Power-good acknowledge from the switch (asynchronous) |
| hw_rst_o | output | 1 | Domain hardware-reset control |
| pon_req_o | output | 1 | Power-on request |
| pg_req_o | output | 1 | Power-good request |
| clamp_o | output | 1 | Isolation clamp enable |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Sticky timeout error |
| err_stage_o | output | 1 | Failed stage: 0 power-on, 1 power-good |
| reg_addr_i | input | ADDR_W | Register view byte offset |
| reg_rdata_o | output | DATA_W | Register view read data |

## Verification

The assertions assume that each acknowledge only rises after its own request has risen and stays high until reset. They also assume that start_i is a clean single-cycle pulse; a held start would simply re-trigger from the idle state.

The bench's switch model follows this rule. It raises each acknowledge a chosen number of cycles after seeing its request, or never, and drops it only under reset. It drives start as one-cycle pulses away from the clock edge.

Stimulus then varies the acknowledge delays: immediate, near the last poll, and never. It also places start pulses during a run, after completion and after an error.

// File: rtl/pus_pkg.sv
package pus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PON_REQ,
    ST_PON_POLL,
    ST_PON_SETTLE,
    ST_PG_POLL,
    ST_PG_SETTLE,
    ST_UNCLAMP,
    ST_FAIL
  } seq_state_e;

  // byte offsets of the register view
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_PWREN = 4;
  localparam int unsigned OFS_STAT  = 8;

  // bit positions inside the register words
  localparam int BIT_HWRST = 6;
  localparam int BIT_CLAMP = 20;
  localparam int BIT_PON   = 21;
  localparam int BIT_PGOOD = 22;
  localparam int BIT_DONE  = 0;
  localparam int BIT_BUSY  = 1;
  localparam int BIT_ERR   = 2;
  localparam int BIT_ESTG  = 3;

  // cycles covering ns nanoseconds at hz, rounded up, never below one
  function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/pus_sync.sv
module pus_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/pus_timer.sv
module pus_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             zero_o
);

  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load_i)     cnt <= val_i;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);

  // R8: settle and poll gaps shrink by exactly one per cycle
  a_r8_tmr_step: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pus_fsm.sv
module pus_fsm
  import pus_pkg::*;
#(
  parameter int POLL_CYC   = 100,
  parameter int SETTLE_CYC = 50,
  parameter int POLL_LIMIT = 10,
  parameter int TMR_W      = 7,
  parameter int POLL_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             pon_ack_i,
  input  logic             pg_ack_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output logic             hw_rst_o,
  output logic             pon_req_o,
  output logic             pg_req_o,
  output logic             clamp_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             err_stage_o
);

  localparam logic [TMR_W-1:0]  POLL_RELOAD = TMR_W'(POLL_CYC - 1);
  localparam logic [TMR_W-1:0]  SETL_RELOAD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [POLL_W-1:0] LAST_POLL   = POLL_W'(POLL_LIMIT - 1);

  seq_state_e        state;
  logic [POLL_W-1:0] polls;
  logic              cur_ack;
  logic              last_poll;

  assign cur_ack   = (state == ST_PG_POLL) ? pg_ack_i : pon_ack_i;
  assign last_poll = (polls == LAST_POLL);

  // timer reload requests
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state)
      ST_PON_POLL, ST_PG_POLL: begin
        if (tmr_zero_i) begin
          if (cur_ack) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = SETL_RELOAD;
          end else if (!last_poll) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = POLL_RELOAD;
          end
        end
      end
      ST_PG_SETTLE: begin
        if (tmr_zero_i) begin
          tmr_load_o = 1'b1;
          tmr_val_o  = SETL_RELOAD;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      polls       <= '0;
      hw_rst_o    <= 1'b1;
      pon_req_o   <= 1'b0;
      pg_req_o    <= 1'b0;
      clamp_o     <= 1'b1;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      err_stage_o <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            hw_rst_o <= 1'b0;
            busy_o   <= 1'b1;
            done_o   <= 1'b0;
            state    <= ST_PON_REQ;
          end
        end
        ST_PON_REQ: begin
          pon_req_o <= 1'b1;
          polls     <= '0;
          state     <= ST_PON_POLL;
        end
        ST_PON_POLL, ST_PG_POLL: begin
          if (tmr_zero_i) begin
            if (cur_ack) begin
              state <= (state == ST_PON_POLL) ? ST_PON_SETTLE : ST_PG_SETTLE;
            end else if (last_poll) begin
              err_o       <= 1'b1;
              err_stage_o <= (state == ST_PG_POLL);
              busy_o      <= 1'b0;
              state       <= ST_FAIL;
            end else begin
              polls <= polls + 1'b1;
            end
          end
        end
        ST_PON_SETTLE: begin
          if (tmr_zero_i) begin
            pg_req_o <= 1'b1;
            polls    <= '0;
            state    <= ST_PG_POLL;
          end
        end
        ST_PG_SETTLE: begin
          if (tmr_zero_i) begin
            clamp_o <= 1'b0;
            state   <= ST_UNCLAMP;
          end
        end
        ST_UNCLAMP: begin
          if (tmr_zero_i) begin
            hw_rst_o <= 1'b1;
            done_o   <= 1'b1;
            busy_o   <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_FAIL: ;
        default: state <= ST_FAIL;
      endcase
    end
  end

  // R6: the power-good request never leads the power-on request
  a_r6_pg_after_pon: assert property (@(posedge clk) disable iff (rst)
    pg_req_o |-> pon_req_o);

  // R7: clamp only released once power-good was requested
  a_r7_clamp_after_pg: assert property (@(posedge clk) disable iff (rst)
    !clamp_o |-> pg_req_o);

  // R8: a finished domain is out of reset and unclamped
  a_r8_done_state: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (hw_rst_o && !clamp_o && !busy_o));

  // R12: the error flag and outputs hold once raised
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> (err_o && $stable(err_stage_o) && $stable(pon_req_o) && $stable(pg_req_o)));

  // R5: error and done are never both reported
  a_r5_err_xor_done: assert property (@(posedge clk) disable iff (rst)
    !(err_o && done_o));

endmodule

// File: rtl/pus_regview.sv
module pus_regview
  import pus_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hw_rst_i,
  input  logic              clamp_i,
  input  logic              pon_req_i,
  input  logic              pg_req_i,
  input  logic              pon_ack_i,
  input  logic              pg_ack_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic              err_i,
  input  logic              err_stage_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] w_ctrl, w_pwren, w_stat;
  logic              hit;

  always_comb begin
    w_ctrl  = '0;
    w_pwren = '0;
    w_stat  = '0;
    w_ctrl[BIT_HWRST]  = hw_rst_i;
    w_pwren[BIT_CLAMP] = clamp_i;
    w_pwren[BIT_PON]   = pon_req_i;
    w_pwren[BIT_PGOOD] = pg_req_i;
    w_stat[BIT_DONE]   = done_i;
    w_stat[BIT_BUSY]   = busy_i;
    w_stat[BIT_ERR]    = err_i;
    w_stat[BIT_ESTG]   = err_stage_i;
    w_stat[BIT_PON]    = pon_ack_i;
    w_stat[BIT_PGOOD]  = pg_ack_i;
  end

  assign hit = (addr_i == ADDR_W'(OFS_CTRL)) || (addr_i == ADDR_W'(OFS_PWREN)) ||
               (addr_i == ADDR_W'(OFS_STAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      if (addr_i == ADDR_W'(OFS_CTRL))       rdata_o <= w_ctrl;
      else if (addr_i == ADDR_W'(OFS_PWREN)) rdata_o <= w_pwren;
      else if (addr_i == ADDR_W'(OFS_STAT))  rdata_o <= w_stat;
      else                                   rdata_o <= '0;
    end
  end

  // R13: an unmapped offset reads back as zero on the next cycle
  a_r13_hole_zero: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (rdata_o == '0));

endmodule

// File: rtl/pwr_up_seq.sv
module pwr_up_seq
  import pus_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned POLL_NS     = 1000,
  parameter int unsigned SETTLE_NS   = 500,
  parameter int          POLL_LIMIT  = 10,
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              pon_ack_i,
  input  logic              pg_ack_i,
  output logic              hw_rst_o,
  output logic              pon_req_o,
  output logic              pg_req_o,
  output logic              clamp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              err_stage_o,
  input  logic [ADDR_W-1:0] reg_addr_i,
  output logic [DATA_W-1:0] reg_rdata_o
);

  localparam int POLL_CYC   = int'(ns_to_cyc(longint'(CLK_HZ), longint'(POLL_NS)));
  localparam int SETTLE_CYC = int'(ns_to_cyc(longint'(CLK_HZ), longint'(SETTLE_NS)));
  localparam int TMR_MAX    = (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int POLL_W     = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  logic [1:0]       ack_raw, ack_s;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;

  assign ack_raw = {pg_ack_i, pon_ack_i};

  pus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ack_raw),
    .q_o (ack_s)
  );

  pus_timer #(.TMR_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  pus_fsm #(
    .POLL_CYC   (POLL_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .POLL_LIMIT (POLL_LIMIT),
    .TMR_W      (TMR_W),
    .POLL_W     (POLL_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .pon_ack_i   (ack_s[0]),
    .pg_ack_i    (ack_s[1]),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .hw_rst_o    (hw_rst_o),
    .pon_req_o   (pon_req_o),
    .pg_req_o    (pg_req_o),
    .clamp_o     (clamp_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_stage_o (err_stage_o)
  );

  pus_regview #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (reg_addr_i),
    .hw_rst_i    (hw_rst_o),
    .clamp_i     (clamp_o),
    .pon_req_i   (pon_req_o),
    .pg_req_i    (pg_req_o),
    .pon_ack_i   (ack_s[0]),
    .pg_ack_i    (ack_s[1]),
    .done_i      (done_o),
    .busy_i      (busy_o),
    .err_i       (err_o),
    .err_stage_i (err_stage_o),
    .rdata_o     (reg_rdata_o)
  );

  // R2: a start accepted from idle raises busy and lowers reset together
  a_r2_start_takes: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !err_o) |=> (busy_o && !hw_rst_o));

  // R11: a start during a run does not end the run early
  a_r11_busy_start: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o && !clamp_o) |=> (busy_o || done_o));

endmodule

// File: tb/pwr_up_seq_tb.sv
module pwr_up_seq_tb;

  localparam int unsigned CLK_HZ = 100_000_000;
  localparam int P = (CLK_HZ + 999_999) / 1_000_000;
  localparam int S = (CLK_HZ / 1000 * 500 + 999_999) / 1_000_000;
  localparam int L = 10;
  localparam int NEVER = -1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        pon_ack = 1'b0, pg_ack = 1'b0;
  logic [3:0]  raddr = 4'h0;
  logic [31:0] rdata;
  logic hw_rst, pon_req, pg_req, clamp, busy, done, err, estg;

  int checks = 0, errors = 0;
  int cyc = 0;
  int pon_dly = 0, pg_dly = 0, pon_cnt = 0, pg_cnt = 0;
  int t_pon_ack, t_pg_ack, t_rst_fall, t_rst_rise, t_pon_rise, t_pg_rise, t_clamp_fall, t_err_rise;
  logic [7:0] exp_q[$];
  logic [7:0] prev;

  always #5 clk = ~clk;

  pwr_up_seq #(.CLK_HZ(CLK_HZ), .POLL_LIMIT(L)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .pon_ack_i(pon_ack), .pg_ack_i(pg_ack),
    .hw_rst_o(hw_rst), .pon_req_o(pon_req), .pg_req_o(pg_req), .clamp_o(clamp),
    .busy_o(busy), .done_o(done), .err_o(err), .err_stage_o(estg),
    .reg_addr_i(raddr), .reg_rdata_o(rdata)
  );

  // vector bits: busy done err stage clamp pg pon rst
  function automatic logic [7:0] mk(bit b, bit d, bit e, bit st, bit c, bit g, bit p, bit r);
    return {b, d, e, st, c, g, p, r};
  endfunction

  wire [7:0] vec = {busy, done, err, estg, clamp, pg_req, pon_req, hw_rst};

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic chk_range(string req, int v, int lo, int hi);
    checks++;
    if (v < lo || v > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, v, lo, hi);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  // switch model: acknowledges a chosen delay after each request
  always @(negedge clk) begin
    if (rst || !pon_req) begin
      pon_ack <= 1'b0; pon_cnt = 0;
    end else if (!pon_ack) begin
      if (pon_dly != NEVER && pon_cnt >= pon_dly) begin
        pon_ack <= 1'b1; t_pon_ack = cyc;
      end else pon_cnt++;
    end
    if (rst || !pg_req) begin
      pg_ack <= 1'b0; pg_cnt = 0;
    end else if (!pg_ack) begin
      if (pg_dly != NEVER && pg_cnt >= pg_dly) begin
        pg_ack <= 1'b1; t_pg_ack = cyc;
      end else pg_cnt++;
    end
  end

  // monitor: each output change is popped against the scoreboard (R9)
  always @(negedge clk) begin
    logic [7:0] e;
    if (rst) prev = vec;
    else if (vec !== prev) begin
      if (prev[0] && !vec[0]) t_rst_fall = cyc;
      if (!prev[0] && vec[0]) t_rst_rise = cyc;
      if (!prev[1] && vec[1]) t_pon_rise = cyc;
      if (!prev[2] && vec[2]) t_pg_rise = cyc;
      if (prev[3] && !vec[3]) t_clamp_fall = cyc;
      if (!prev[5] && vec[5]) t_err_rise = cyc;
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected change", vec, prev);
      else begin
        e = exp_q.pop_front();
        chk(vec === e, "R9 output step", vec, e);
      end
      prev = vec;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    rst = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); raddr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || err) && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic push_normal();
    exp_q.push_back(mk(1,0,0,0,1,0,0,0));
    exp_q.push_back(mk(1,0,0,0,1,0,1,0));
    exp_q.push_back(mk(1,0,0,0,1,1,1,0));
    exp_q.push_back(mk(1,0,0,0,0,1,1,0));
    exp_q.push_back(mk(0,1,0,0,0,1,1,1));
  endtask

  initial begin
    logic [31:0] d;
    do_reset();
    // R1 reset state
    chk(vec === mk(0,0,0,0,1,0,0,1), "R1 reset outputs", vec, mk(0,0,0,0,1,0,0,1));
    rd(4'h0, d); chk(d == 32'h40, "R13 ctrl at reset", d, 32'h40);
    rd(4'h4, d); chk(d == 32'h0010_0000, "R13 pwren at reset", d, 32'h0010_0000);
    rd(4'h8, d); chk(d == 32'h0, "R13 status at reset", d, 0);

    // normal run, immediate power-on ack, late-ish power-good ack
    pon_dly = 0; pg_dly = 20;
    push_normal();
    pulse(); wait_end();
    repeat (5) @(negedge clk);
    chk(t_pon_rise - t_rst_fall == 1, "R2 pon one cycle after reset low", t_pon_rise - t_rst_fall, 1);
    chk_range("R6 pg after pon ack", t_pg_rise - t_pon_ack, S, S + P + 3);
    chk_range("R7 clamp after pg ack", t_clamp_fall - t_pg_ack, S, S + P + 3);
    chk(t_rst_rise - t_clamp_fall == S, "R8 reset after clamp", t_rst_rise - t_clamp_fall, S);
    chk(exp_q.size() == 0, "R9 all steps seen", exp_q.size(), 0);
    repeat (100) @(negedge clk);
    chk(done && !busy, "R10 done holds", {done, busy}, 2'b10);
    rd(4'h0, d); chk(d == 32'h40, "R13 ctrl after done", d, 32'h40);
    rd(4'h4, d); chk(d == 32'h0060_0000, "R13 pwren after done", d, 32'h0060_0000);
    rd(4'h8, d); chk(d == 32'h0060_0001, "R13 status after done", d, 32'h0060_0001);
    rd(4'hC, d); chk(d == 32'h0, "R13 unmapped offset", d, 0);

    // R10 restart from done
    exp_q.push_back(mk(1,0,0,0,0,1,1,0));
    exp_q.push_back(mk(0,1,0,0,0,1,1,1));
    pulse(); wait_end();
    repeat (5) @(negedge clk);
    chk(done && exp_q.size() == 0, "R10 restart completes", exp_q.size(), 0);

    // R3 late ack near the last poll, R11 start during a run
    do_reset();
    pon_dly = 850; pg_dly = 0;
    push_normal();
    pulse();
    repeat (300) @(negedge clk);
    pulse();
    wait_end();
    repeat (5) @(negedge clk);
    chk(done && !err, "R3 late ack accepted", {done, err}, 2'b10);
    chk(exp_q.size() == 0, "R11 start while busy ignored", exp_q.size(), 0);
    chk(t_rst_rise - t_clamp_fall == S, "R11 timing unchanged", t_rst_rise - t_clamp_fall, S);

    // R4 R5 power-on timeout, R12 sticky
    do_reset();
    pon_dly = NEVER; pg_dly = 0;
    exp_q.push_back(mk(1,0,0,0,1,0,0,0));
    exp_q.push_back(mk(1,0,0,0,1,0,1,0));
    exp_q.push_back(mk(0,0,1,0,1,0,1,0));
    pulse(); wait_end();
    repeat (3) @(negedge clk);
    chk_range("R4 power-on timeout window", t_err_rise - t_pon_rise, (L - 1) * P, L * P);
    chk(err && !estg && !busy, "R5 stage power-on", {err, estg, busy}, 3'b100);
    pulse();
    repeat (200) @(negedge clk);
    chk(vec === mk(0,0,1,0,1,0,1,0), "R12 start ignored after error", vec, mk(0,0,1,0,1,0,1,0));

    // R4 R5 power-good timeout
    do_reset();
    pon_dly = 0; pg_dly = NEVER;
    exp_q.push_back(mk(1,0,0,0,1,0,0,0));
    exp_q.push_back(mk(1,0,0,0,1,0,1,0));
    exp_q.push_back(mk(1,0,0,0,1,1,1,0));
    exp_q.push_back(mk(0,0,1,1,1,1,1,0));
    pulse(); wait_end();
    repeat (3) @(negedge clk);
    chk_range("R4 power-good timeout window", t_err_rise - t_pg_rise, (L - 1) * P, L * P);
    chk(err && estg, "R5 stage power-good", {err, estg}, 2'b11);
    rd(4'h8, d); chk(d == 32'h0020_000C, "R13 status after error", d, 32'h0020_000C);
    chk(exp_q.size() == 0, "R9 error steps seen", exp_q.size(), 0);

    do_reset();
    chk(vec === mk(0,0,0,0,1,0,0,1), "R12 reset clears error", vec, mk(0,0,0,0,1,0,0,1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule